// File: doc/BRIEF.md
# Hub Return-Address Stack with Wrap and Collision Flags

This block holds return addresses for hub call and hub return instructions of one processor core. It owns a small local memory, a stack pointer that steps down before each push and up after each pop, and a three-state controller that tracks the execution mode. A call stores the address of the instruction that follows it. A return hands back the stored address plus a word-scaled offset. A non-zero offset lets one return skip several call levels at once, for example to unwind an exception.

Each entry carries an origin marker. The marker records whether the call was made while the core executed from local memory. When a return pops a marked entry, the controller leaves hub mode, and execution resumes in local memory after the instruction that entered hub mode. A call made while already in hub mode pushes a normal entry and keeps hub mode. On request, a call or a return also reports two flags. One reports that the pointer wrapped around the memory bounds. The other reports that the new pointer equals a second pointer that shares the same memory.

The controller has three states. In ST_LOCAL the core runs local code, and only a call is accepted (transition ENTER to ST_HUB). In ST_HUB both operations are accepted: a call loops back (NEST), and a return moves to ST_POP (UNWIND). ST_POP lasts one cycle and presents the returned data. It then goes to ST_LOCAL when the popped marker is set (LEAVE), or back to ST_HUB when it is clear (RESUME).

Top module: `hub_ret_stack`

## Requirements
- R1: After reset, sp is 255, hub_mode is 0, and ret_valid, flag_c_we and flag_z_we are 0.
- R2: An accepted call lowers sp by 1 (modulo 256) one cycle later. It stores call_next_pc at the new sp, and hub_mode is 1 afterwards.
- R3: An accepted return raises ret_valid for exactly the next cycle. In that cycle ret_pc equals the entry at the old sp plus 4 × ret_offset (modulo 2^32), and sp has risen by 1 (modulo 256).
- R4: When upd_c is 1 with an accepted operation, flag_c_we pulses the next cycle. flag_c is then 1 exactly when the pointer crossed the bound: a push from sp 0 or a pop from sp 255.
- R5: When upd_z is 1 with an accepted operation, flag_z_we pulses the next cycle. flag_z is then 1 exactly when the new sp equals other_ptr.
- R6: A call accepted while hub_mode is 0 marks its entry. A return that pops a marked entry shows ret_to_local = 1 and leaves hub_mode at 0 one cycle after ret_valid.
- R7: A call accepted while hub_mode is 1 stores an unmarked entry. Popping that entry shows ret_to_local = 0, and hub_mode stays 1.
- R8: A return requested while hub_mode is 0 is ignored: sp does not change and ret_valid stays 0.
- R9: When a call and a return are requested in the same cycle, only the call is performed. A request made in the cycle where ret_valid is 1 is ignored.
- R10: flag_c_we and flag_z_we stay 0 after any cycle without an accepted operation, or without the matching update request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_req | input | 1 | Hub call request |
| call_next_pc | input | 32 | Address of the instruction after the call |
| ret_req | input | 1 | Hub return request |
| ret_offset | input | 9 | Return offset in words |
| upd_c | input | 1 | Request a wrap-flag update |
| upd_z | input | 1 | Request a collision-flag update |
| other_ptr | input | 8 | Second pointer into the same memory |
| hub_mode | output | 1 | 1 while hub code executes |
| sp | output | 8 | Stack pointer |
| ret_valid | output | 1 | Return data valid |
| ret_pc | output | 32 | Return target |
| ret_to_local | output | 1 | Return resumes local execution |
| flag_c_we | output | 1 | Wrap-flag write strobe |
| flag_c | output | 1 | Wrap flag value |
| flag_z_we | output | 1 | Collision-flag write strobe |
| flag_z | output | 1 | Collision flag value |

## Verification
The bench pushes 300 nested calls from reset, so the pointer crosses zero and the oldest entries are overwritten. It then pops every entry and one more, which crosses the top bound. A design that tested the bound after the pointer moved, instead of before, would flag the wrong push or pop. A post-decrementing push would return every address one entry off. The collision pointer is placed so that it is met both while pushing and while popping. Further cases cover an offset that overflows 32 bits, a held return request, a call and a return requested together, and a return from local mode. A design with a wrong or missing origin marker would stay in hub mode or leave it too early.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Execution-mode controller states
    typedef enum logic [1:0] {
        ST_LOCAL = 2'd0,
        ST_HUB   = 2'd1,
        ST_POP   = 2'd2
    } rs_state_e;

    // Pointer operation selected for a cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } rs_op_e;

endpackage

// File: rtl/rs_mode_fsm.sv
module rs_mode_fsm
    import rs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   call_req,
    input  logic   ret_req,
    input  logic   marker_rd,
    output rs_op_e op,
    output logic   origin_local,
    output logic   hub_mode,
    output logic   ret_valid,
    output logic   ret_to_local
);

    rs_state_e state_q;
    rs_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and accepted operation
    always_comb begin
        state_d = state_q;
        op      = OP_NONE;
        unique case (state_q)
            ST_LOCAL: begin
                if (call_req) begin
                    op      = OP_PUSH;
                    state_d = ST_HUB;        // ENTER
                end
            end
            ST_HUB: begin
                if (call_req) begin
                    op      = OP_PUSH;       // NEST
                end else if (ret_req) begin
                    op      = OP_POP;
                    state_d = ST_POP;        // UNWIND
                end
            end
            ST_POP: begin
                state_d = marker_rd ? ST_LOCAL : ST_HUB;  // LEAVE / RESUME
            end
            default: state_d = ST_LOCAL;
        endcase
    end

    // Outputs
    always_comb begin
        origin_local = (state_q == ST_LOCAL);
        hub_mode     = (state_q != ST_LOCAL);
        ret_valid    = (state_q == ST_POP);
        ret_to_local = (state_q == ST_POP) && marker_rd;
    end

endmodule

// File: rtl/rs_ptr_unit.sv
module rs_ptr_unit
    import rs_pkg::*;
#(
    parameter int PTR_W = 8,
    parameter logic [PTR_W-1:0] SP_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rs_op_e           op,
    input  logic             upd_c,
    input  logic             upd_z,
    input  logic [PTR_W-1:0] other_ptr,
    output logic [PTR_W-1:0] sp,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic             flag_c_we,
    output logic             flag_c,
    output logic             flag_z_we,
    output logic             flag_z
);

    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_d;
    logic             wrap;
    logic             active;

    always_comb begin
        sp_d = sp_q;
        wrap = 1'b0;
        unique case (op)
            OP_PUSH: begin
                sp_d = sp_q - 1'b1;
                wrap = (sp_q == '0);
            end
            OP_POP: begin
                sp_d = sp_q + 1'b1;
                wrap = (sp_q == '1);
            end
            default: begin
                sp_d = sp_q;
                wrap = 1'b0;
            end
        endcase
    end

    assign active = (op != OP_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q      <= SP_RESET;
            flag_c_we <= 1'b0;
            flag_c    <= 1'b0;
            flag_z_we <= 1'b0;
            flag_z    <= 1'b0;
        end else begin
            sp_q      <= sp_d;
            flag_c_we <= active && upd_c;
            flag_z_we <= active && upd_z;
            if (active && upd_c) flag_c <= wrap;
            if (active && upd_z) flag_z <= (sp_d == other_ptr);
        end
    end

    assign sp     = sp_q;
    assign wr_idx = sp_q - 1'b1;
    assign rd_idx = sp_q;

endmodule

// File: rtl/rs_store.sv
module rs_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wmark,
    input  logic              re,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic              rmark
);

    // Entry = origin marker in the top bit, address below
    logic [DATA_W:0] mem [DEPTH];
    logic [DATA_W:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= {wmark, wdata};
        end
        if (re) begin
            rd_q <= mem[ridx];
        end
    end

    assign rdata = rd_q[DATA_W-1:0];
    assign rmark = rd_q[DATA_W];

endmodule

// File: rtl/hub_ret_stack.sv
module hub_ret_stack
    import rs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    parameter int OFF_W  = 9,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic [DATA_W-1:0] call_next_pc,
    input  logic              ret_req,
    input  logic [OFF_W-1:0]  ret_offset,
    input  logic              upd_c,
    input  logic              upd_z,
    input  logic [PTR_W-1:0]  other_ptr,
    output logic              hub_mode,
    output logic [PTR_W-1:0]  sp,
    output logic              ret_valid,
    output logic [DATA_W-1:0] ret_pc,
    output logic              ret_to_local,
    output logic              flag_c_we,
    output logic              flag_c,
    output logic              flag_z_we,
    output logic              flag_z
);

    localparam int PAD_W = DATA_W - OFF_W - 2;

    rs_op_e            op;
    logic              origin_local;
    logic              marker_rd;
    logic [DATA_W-1:0] data_rd;
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  rd_idx;
    logic [OFF_W-1:0]  off_q;
    logic              push_go;
    logic              pop_go;

    assign push_go = (op == OP_PUSH);
    assign pop_go  = (op == OP_POP);

    rs_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .call_req     (call_req),
        .ret_req      (ret_req),
        .marker_rd    (marker_rd),
        .op           (op),
        .origin_local (origin_local),
        .hub_mode     (hub_mode),
        .ret_valid    (ret_valid),
        .ret_to_local (ret_to_local)
    );

    rs_ptr_unit #(
        .PTR_W    (PTR_W),
        .SP_RESET ({PTR_W{1'b1}})
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .upd_c     (upd_c),
        .upd_z     (upd_z),
        .other_ptr (other_ptr),
        .sp        (sp),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .flag_c_we (flag_c_we),
        .flag_c    (flag_c),
        .flag_z_we (flag_z_we),
        .flag_z    (flag_z)
    );

    rs_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (push_go),
        .widx  (wr_idx),
        .wdata (call_next_pc),
        .wmark (origin_local),
        .re    (pop_go),
        .ridx  (rd_idx),
        .rdata (data_rd),
        .rmark (marker_rd)
    );

    // Offset held for the cycle the popped data appears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (pop_go) begin
            off_q <= ret_offset;
        end
    end

    assign ret_pc = data_rd + {{PAD_W{1'b0}}, off_q, 2'b00};

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_go,
    input logic             pop_go,
    input logic             upd_c,
    input logic             hub_mode,
    input logic             call_req,
    input logic [PTR_W-1:0] sp,
    input logic             ret_valid,
    input logic             flag_c_we,
    input logic             flag_c,
    input logic             flag_z_we
);

    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_go |=> (sp == $past(sp) - 1'b1) && hub_mode);

    assert_pop_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_go |=> ret_valid && (sp == $past(sp) + 1'b1));

    assert_valid_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !ret_valid);

    assert_wrap_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_go && upd_c && sp == '0) |=> flag_c_we && flag_c);

    assert_local_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hub_mode && !call_req) |=> $stable(sp) && !ret_valid);

    assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_go || pop_go) |=> !flag_c_we && !flag_z_we);

endmodule

bind hub_ret_stack rs_checker #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_go   (push_go),
    .pop_go    (pop_go),
    .upd_c     (upd_c),
    .hub_mode  (hub_mode),
    .call_req  (call_req),
    .sp        (sp),
    .ret_valid (ret_valid),
    .flag_c_we (flag_c_we),
    .flag_c    (flag_c),
    .flag_z_we (flag_z_we)
);

// File: tb/tb_hub_ret_stack.sv
`timescale 1ns/1ps
module tb_hub_ret_stack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0;
    logic [31:0] call_next_pc = '0;
    logic        ret_req = 1'b0;
    logic [8:0]  ret_offset = '0;
    logic        upd_c = 1'b0;
    logic        upd_z = 1'b0;
    logic [7:0]  other_ptr = 8'd100;
    logic        hub_mode;
    logic [7:0]  sp;
    logic        ret_valid;
    logic [31:0] ret_pc;
    logic        ret_to_local;
    logic        flag_c_we, flag_c, flag_z_we, flag_z;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model
    logic [31:0] m_val [256];
    logic        m_mark [256];
    logic [7:0]  m_sp;
    logic        m_hub;

    always #10 clk = ~clk;

    hub_ret_stack dut (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_next_pc(call_next_pc),
        .ret_req(ret_req), .ret_offset(ret_offset), .upd_c(upd_c), .upd_z(upd_z),
        .other_ptr(other_ptr), .hub_mode(hub_mode), .sp(sp), .ret_valid(ret_valid),
        .ret_pc(ret_pc), .ret_to_local(ret_to_local), .flag_c_we(flag_c_we),
        .flag_c(flag_c), .flag_z_we(flag_z_we), .flag_z(flag_z)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        call_req = 0; ret_req = 0; upd_c = 0; upd_z = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_sp = 8'd255;
        m_hub = 1'b0;
        @(negedge clk);
        chk(sp == 8'd255, "R1 sp", sp, 255);
        chk(hub_mode == 0, "R1 hub_mode", hub_mode, 0);
        chk(!ret_valid && !flag_c_we && !flag_z_we, "R1 strobes",
            {ret_valid, flag_c_we, flag_z_we}, 0);
    endtask

    task automatic do_call(input logic [31:0] a, input bit c, input bit z);
        logic [7:0] old;
        old = m_sp;
        call_req = 1; call_next_pc = a; upd_c = c; upd_z = z;
        @(negedge clk);
        call_req = 0; upd_c = 0; upd_z = 0;
        m_sp = old - 8'd1;
        m_val[m_sp] = a;
        m_mark[m_sp] = !m_hub;
        m_hub = 1;
        chk(sp == m_sp, "R2 sp after call", sp, m_sp);
        chk(hub_mode == 1, "R2 hub_mode after call", hub_mode, 1);
        chk(flag_c_we == c, "R10 c strobe on call", flag_c_we, c);
        chk(flag_z_we == z, "R10 z strobe on call", flag_z_we, z);
        if (c) chk(flag_c == (old == 8'd0), "R4 wrap on push", flag_c, old == 8'd0);
        if (z) chk(flag_z == (m_sp == other_ptr), "R5 collision on push", flag_z, m_sp == other_ptr);
    endtask

    task automatic do_ret(input logic [8:0] off, input bit c, input bit z);
        logic [7:0]  old;
        logic [31:0] e;
        old = m_sp;
        e = m_val[old] + {21'd0, off, 2'b00};
        ret_req = 1; ret_offset = off; upd_c = c; upd_z = z;
        @(negedge clk);
        ret_req = 0; upd_c = 0; upd_z = 0;
        m_sp = old + 8'd1;
        chk(ret_valid == 1, "R3 ret_valid", ret_valid, 1);
        chk(ret_pc == e, "R3 ret_pc", ret_pc, e);
        chk(sp == m_sp, "R3 sp after return", sp, m_sp);
        chk(ret_to_local == m_mark[old], "R6 R7 ret_to_local", ret_to_local, m_mark[old]);
        if (c) chk(flag_c == (old == 8'd255), "R4 wrap on pop", flag_c, old == 8'd255);
        if (z) chk(flag_z == (m_sp == other_ptr), "R5 collision on pop", flag_z, m_sp == other_ptr);
        chk(flag_c_we == c && flag_z_we == z, "R10 strobes on return",
            {flag_c_we, flag_z_we}, {c, z});
        @(negedge clk);
        m_hub = !m_mark[old];
        chk(hub_mode == m_hub, "R6 R7 mode after return", hub_mode, m_hub);
        chk(ret_valid == 0, "R3 ret_valid one cycle", ret_valid, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();

        // R8: return from local mode ignored
        ret_req = 1;
        @(negedge clk);
        ret_req = 0;
        chk(sp == 8'd255, "R8 sp unchanged", sp, 255);
        chk(ret_valid == 0, "R8 no ret_valid", ret_valid, 0);

        // Deep sweep: 300 nested calls, pointer crosses zero
        for (int i = 0; i < 300; i++) begin
            do_call(32'h1000_0000 ^ (i * 32'h9E37_79B9), (i % 2) == 0 || i == 255, (i % 3) == 0 || i == 154);
        end
        // Unwind all, then one more across the top bound
        for (int i = 0; i < 301; i++) begin
            do_ret(9'((i * 37) % 512), 1'b1, (i % 2) == 1 || i == 144);
        end

        // Offset overflow and origin marker, after a fresh reset
        do_reset();
        do_call(32'h0000_0040, 1, 1);         // R6 enter from local
        do_call(32'h0002_0000, 0, 0);         // R7 nested
        do_call(32'hFFFF_FFF8, 0, 0);         // R7 nested
        do_ret(9'h1FF, 0, 0);                 // R3 overflow wraps 32 bits

        // R9: call and return together -> call only
        call_req = 1; ret_req = 1; call_next_pc = 32'hABCD_0000;
        @(negedge clk);
        call_req = 0; ret_req = 0;
        m_sp = m_sp - 8'd1; m_val[m_sp] = 32'hABCD_0000; m_mark[m_sp] = 0;
        chk(sp == m_sp, "R9 call wins sp", sp, m_sp);
        chk(ret_valid == 0, "R9 no ret_valid", ret_valid, 0);

        // R9: held return request pops once per accepted cycle
        ret_req = 1; ret_offset = 0;
        @(negedge clk);
        chk(ret_valid == 1 && ret_pc == 32'hABCD_0000, "R9 first pop", ret_pc, 32'hABCD_0000);
        @(negedge clk);
        ret_req = 0;
        chk(sp == m_sp + 8'd1, "R9 held request ignored in pop cycle", sp, m_sp + 8'd1);
        m_sp = m_sp + 8'd1;
        m_hub = 1;
        @(negedge clk);
        chk(ret_valid == 0 && hub_mode == 1, "R9 idle after pop", {ret_valid, hub_mode}, 1);

        do_ret(0, 0, 0);                      // R7 pops nested entry
        do_ret(0, 0, 0);                      // R6 pops marked entry, back to local
        chk(hub_mode == 0, "R6 back to local", hub_mode, 0);
        @(negedge clk);
        chk(!flag_c_we && !flag_z_we, "R10 idle strobes", {flag_c_we, flag_z_we}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule